// File: doc/BRIEF.md
# OTP protection register controller

This block holds a small one-time-programmable register area of nine 16-bit words, as it sits behind the command interface of a flash memory. One word holds lock bits. Four words hold a factory identifier that is loaded at reset and can never be changed. Four words are free for the user to program until the user locks them. Program requests only ever clear bits: the stored word becomes the AND of the old word and the write data.

Each request carries a byte address and 16 data bits. The block decodes the address, checks the lock state of the segment that the address hits, then applies or rejects the program. Results are reported as sticky error bits in an 8-bit status word, next to a ready bit. Reads return the stored word one cycle later. A read outside the area returns all ones.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset, status_o is 0x80 (ready, no errors). The lock word reads 0xFFFE. The factory words at word indices 0x81..0x84 read the FACTORY_ID parameter, least significant 16 bits first. The user words 0x85..0x88 read 0xFFFF.
- R2: The word index is taken from addr_i[8:1], and addr_i[0] is ignored. An address is inside the area only when addr_i bits above bit 8 are all zero and the word index lies in 0x80..0x88. Word 0x80 is the lock word, 0x81..0x84 are the factory segment, and 0x85..0x88 are the user segment.
- R3: A read request sets rvalid_o high for one cycle, one clock after the request. With it, rdata_o carries the stored word when the address is inside the area, and 0xFFFF when it is outside. A read never changes status_o.
- R4: An accepted program stores the bitwise AND of the old word and wdata_i, so bits only go from 1 to 0.
- R5: A program outside the area sets status bit 4 only and changes no stored word.
- R6: Lock bit 0 is 0 from reset. Any program to the factory segment sets status bits 4 and 1 and leaves the segment unchanged.
- R7: Programming 0xFFFD to the lock word clears lock bit 1, and the lock word then reads 0xFFFC. From then on, programs to the user segment set status bits 4 and 1 and change nothing.
- R8: Once lock bit 1 is 0, any program to the lock word sets status bits 4 and 1 and leaves it unchanged. No lock bit ever returns from 0 to 1.
- R9: Status bits 4 and 1 are sticky until a clr_status_i pulse. When a clear and a new error arrive in the same cycle, the new error is kept.
- R10: Status bit 7 (ready) is 0 for exactly the one cycle that follows each accepted program. It stays 1 for rejected programs and for reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_write_i | input | 1 | 1 = program, 0 = read |
| addr_i | input | ADDR_W | Byte address; bit 0 ignored |
| wdata_i | input | 16 | Program data |
| clr_status_i | input | 1 | Clears the sticky error bits |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid |
| status_o | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
Reads are tried on every word of the area, with address bit 0 both low and high, just past the last word, and with a high address bit set over an otherwise valid index. These reads separate the window decode from the upper-bit check. Programs are tried on an unlocked user word twice with overlapping patterns, which separates an AND from a plain overwrite. Programs outside the area, to the factory segment, to the user segment after locking and to the lock word after locking tell the single-bit error apart from the two-bit lock error. The lock error is also tried together with a clear in the same cycle, which shows the priority between the two.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int DATA_W    = 16;
  localparam int WIDX_W    = 8;
  localparam int SEG_WORDS = 4;
  localparam int PR_WORDS  = 1 + 2 * SEG_WORDS;
  localparam int SLOT_W    = $clog2(PR_WORDS);
  localparam logic [WIDX_W-1:0] PR_BASE = 8'h80;
  localparam logic [WIDX_W-1:0] PR_LAST = WIDX_W'(PR_BASE + PR_WORDS - 1);
  localparam logic [DATA_W-1:0] LOCK_RST = 16'hFFFE;

  localparam int SR_READY    = 7;
  localparam int SR_PGM_ERR  = 4;
  localparam int SR_LOCK_ERR = 1;

  typedef enum logic [1:0] {SEG_LOCK, SEG_FACT, SEG_USER, SEG_NONE} seg_e;

  typedef struct packed {
    logic              hit;
    seg_e              seg;
    logic [SLOT_W-1:0] slot;
  } dec_t;
endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
  import otp_pkg::*;
#(
  parameter int ADDR_W = 25
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  localparam int HI_W = ADDR_W - WIDX_W - 1;

  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] off;
  logic              hi_zero;
  logic              in_win;

  always_comb begin
    widx    = addr_i[WIDX_W:1];
    off     = widx - PR_BASE;
    hi_zero = (addr_i[ADDR_W-1:WIDX_W+1] == '0);
    in_win  = (widx >= PR_BASE) && (widx <= PR_LAST);
    dec_o.hit  = hi_zero && in_win;
    dec_o.slot = off[SLOT_W-1:0];
    if (!dec_o.hit)                             dec_o.seg = SEG_NONE;
    else if (dec_o.slot == '0)                  dec_o.seg = SEG_LOCK;
    else if (dec_o.slot <= SLOT_W'(SEG_WORDS))  dec_o.seg = SEG_FACT;
    else                                        dec_o.seg = SEG_USER;
  end

  logic unused_hi;
  assign unused_hi = ^{HI_W{1'b0}} | addr_i[0];
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        lock_o
);
  logic [DATA_W-1:0] mem_q [PR_WORDS];

  function automatic logic [DATA_W-1:0] rst_word(input int i);
    if (i == 0)              return LOCK_RST;
    else if (i <= SEG_WORDS) return DATA_W'(FACTORY_ID >> ((i - 1) * DATA_W));
    else                     return '1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PR_WORDS; i++) mem_q[i] <= rst_word(i);
    end else if (pgm_i) begin
      mem_q[slot_i] <= mem_q[slot_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[slot_i];
  assign lock_o  = mem_q[0][1:0];

  // R8: lock bits are one-way
  a_r8_lock_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_q[0] & ~$past(mem_q[0])) == '0);

  for (genvar gi = 1; gi <= SEG_WORDS; gi++) begin : g_fact_chk
    a_r6_factory_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(mem_q[gi]));
  end
endmodule

// File: rtl/otp_status.sv
module otp_status
  import otp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       set_pgm_i,
  input  logic       set_lock_i,
  input  logic       busy_i,
  output logic [7:0] status_o
);
  logic err_pgm_q, err_lock_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pgm_q  <= 1'b0;
      err_lock_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      // new errors win over a clear in the same cycle
      err_pgm_q  <= (err_pgm_q  & ~clr_i) | set_pgm_i;
      err_lock_q <= (err_lock_q & ~clr_i) | set_lock_i;
      busy_q     <= busy_i;
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[SR_READY]    = ~busy_q;
    status_o[SR_PGM_ERR]  = err_pgm_q;
    status_o[SR_LOCK_ERR] = err_lock_q;
  end

  a_r9_sticky_pgm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[SR_PGM_ERR] && !clr_i) |=> status_o[SR_PGM_ERR]);
  a_r10_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !status_o[SR_READY]);
  a_r10_ready_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> status_o[SR_READY]);
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W = 25,
  parameter logic [SEG_WORDS*DATA_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              clr_status_i,
  output logic [15:0]       rdata_o,
  output logic              rvalid_o,
  output logic [7:0]        status_o
);
  dec_t              dec;
  logic [1:0]        lock;
  logic [DATA_W-1:0] word;
  logic              is_pgm, is_rd, seg_locked, accept, err_pgm, err_lock;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  otp_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  always_comb begin
    is_pgm = req_valid_i && req_write_i;
    is_rd  = req_valid_i && !req_write_i;
    unique case (dec.seg)
      SEG_FACT: seg_locked = !lock[0];
      SEG_USER: seg_locked = !lock[1];
      SEG_LOCK: seg_locked = !lock[1];   // lock word frozen once user lock set
      default:  seg_locked = 1'b0;
    endcase
    accept   = is_pgm && dec.hit && !seg_locked;
    err_pgm  = is_pgm && (!dec.hit || seg_locked);
    err_lock = is_pgm && dec.hit && seg_locked;
  end

  otp_store #(.FACTORY_ID(FACTORY_ID)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pgm_i   (accept),
    .slot_i  (dec.slot),
    .wdata_i (wdata_i),
    .rdata_o (word),
    .lock_o  (lock)
  );

  otp_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_status_i),
    .set_pgm_i  (err_pgm),
    .set_lock_i (err_lock),
    .busy_i     (accept),
    .status_o   (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '1;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= is_rd;
      if (is_rd) rdata_q <= dec.hit ? word : '1;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r5_out_of_range_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pgm && !dec.hit) |=> status_o[SR_PGM_ERR]);
  a_r6_locked_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pgm && dec.seg == SEG_FACT) |=> (status_o[SR_PGM_ERR] && status_o[SR_LOCK_ERR]));
  a_r3_outside_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && !dec.hit) |=> (rvalid_o && rdata_o == 16'hFFFF));
  a_r3_read_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && !clr_status_i) |=> $stable(status_o[SR_PGM_ERR]));
endmodule

// File: tb/otp_prot_ctrl_test.sv
module otp_prot_ctrl_test;
  localparam int AW = 25;
  localparam logic [63:0] FID = 64'h0123_4567_89AB_CDEF;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          rvalid;
  logic [7:0]    status;

  int errors = 0, checks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  otp_prot_ctrl #(.ADDR_W(AW), .FACTORY_ID(FID)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .addr_i(addr), .wdata_i(wdata), .clr_status_i(clr),
    .rdata_o(rdata), .rvalid_o(rvalid), .status_o(status)
  );

  function automatic logic [AW-1:0] wa(input logic [7:0] w, input logic a0);
    return {{(AW-9){1'b0}}, w, a0};
  endfunction

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  // driver: read pushes expected data to the scoreboard
  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_valid = 1'b1; req_write = 1'b0; addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pg(input logic [AW-1:0] a, input logic [15:0] d, input logic c);
    req_valid = 1'b1; req_write = 1'b1; addr = a; wdata = d; clr = c;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; clr = 1'b0;
  endtask

  task automatic clear_status;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset status", {8'h0, status}, 16'h0080);

    rd(wa(8'h80, 1'b0), 16'hFFFE, "R1 lock word");
    for (int i = 0; i < 4; i++)
      rd(wa(8'h81 + 8'(i), 1'b0), FID[i*16 +: 16], "R1 factory word");
    for (int i = 0; i < 4; i++)
      rd(wa(8'h85 + 8'(i), 1'b0), 16'hFFFF, "R1 user word");
    rd(wa(8'h82, 1'b1), FID[31:16], "R2 a0 ignored");
    rd(wa(8'h89, 1'b0), 16'hFFFF, "R3 past last word");
    rd(wa(8'h85, 1'b0) | (AW'(1) << 9), 16'hFFFF, "R2 high bit set");
    rd(wa(8'h7F, 1'b0), 16'hFFFF, "R2 below base");
    @(negedge clk);
    chk("R3 reads leave status", {8'h0, status}, 16'h0080);

    pg(wa(8'h85, 1'b0), 16'h0F0F, 1'b0);
    chk("R10 ready low after accept", {8'h0, status}, 16'h0000);
    @(negedge clk);
    chk("R10 ready back", {8'h0, status}, 16'h0080);
    pg(wa(8'h85, 1'b1), 16'hF0FF, 1'b0);
    @(negedge clk);
    rd(wa(8'h85, 1'b0), 16'h000F, "R4 and-programming");
    pg(wa(8'h88, 1'b0), 16'h1234, 1'b0);
    @(negedge clk);
    rd(wa(8'h88, 1'b0), 16'h1234, "R4 last user word");

    pg(wa(8'h89, 1'b0), 16'h0000, 1'b0);
    chk("R5 out-of-range flag", {8'h0, status}, 16'h0090);
    rd(wa(8'h89, 1'b0), 16'hFFFF, "R5 nothing stored");
    repeat (3) @(negedge clk);
    chk("R9 sticky", {8'h0, status}, 16'h0090);
    clear_status();
    chk("R9 cleared", {8'h0, status}, 16'h0080);

    pg(wa(8'h82, 1'b0), 16'h0000, 1'b0);
    chk("R6 factory locked flags", {8'h0, status}, 16'h0092);
    rd(wa(8'h82, 1'b0), FID[31:16], "R6 factory unchanged");
    clear_status();

    pg(wa(8'h80, 1'b0), 16'hFFFD, 1'b0);
    chk("R7 lock program accepted", {8'h0, status}, 16'h0000);
    @(negedge clk);
    rd(wa(8'h80, 1'b0), 16'hFFFC, "R7 lock word value");
    pg(wa(8'h86, 1'b0), 16'h0000, 1'b0);
    chk("R7 user locked flags", {8'h0, status}, 16'h0092);
    rd(wa(8'h86, 1'b0), 16'hFFFF, "R7 user unchanged");
    rd(wa(8'h85, 1'b0), 16'h000F, "R7 user content kept");
    clear_status();

    pg(wa(8'h80, 1'b0), 16'hFFF8, 1'b0);
    chk("R8 lock word frozen flags", {8'h0, status}, 16'h0092);
    rd(wa(8'h80, 1'b0), 16'hFFFC, "R8 lock word unchanged");

    pg(wa(8'h83, 1'b0), 16'h0000, 1'b1);
    chk("R9 new error beats clear", {8'h0, status}, 16'h0092);
    clear_status();
    chk("R9 final clear", {8'h0, status}, 16'h0080);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: missing read data actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule